// File: doc/BRIEF.md
# Key-Locked Configuration Port

This block is a byte-wide configuration port that sits behind a host I/O bus and occupies a small window of offsets. Two offsets in the window matter: an index register and a data register. The whole configuration space stays hidden until the host writes an opening key to the index register twice in a row. The host closes the space again by writing a closing key.

While the space is open, the host writes a register number to the index offset and then reads or writes that register through the data offset. The register file holds read-only identity bytes for the chip and its vendor, and a device-select register. It also holds one bank per logical device, and each bank carries that device's relocatable 16-bit I/O base. The base of the monitor device is driven out continuously for a downstream address decoder. That decoder works on 8-byte windows, so the three low bits of the output are always cleared.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the port is closed, reads at the index and data offsets return 0xFF, and `mon_base` equals `BASE_RST` with its three low bits cleared.
- R2: The port opens when two consecutive writes both put 0x87 at offset 5 (the index offset).
- R3: Any write between the two key writes restarts the sequence and leaves the port closed. This covers a different value, or a write to another offset.
- R4: While the port is closed, a read at offset 6 (the data offset) returns 0xFF and a write there changes no register.
- R5: Writing 0xAA to offset 5 while open closes the port. The index is left as it was, and bank contents are kept.
- R6: While open, index 0x20 reads the high byte of `CHIP_ID` and 0x21 reads its low byte. Index 0x23 reads the high byte of `VENDOR_ID` (default 0x1934) and 0x24 reads its low byte.
- R7: The identity registers ignore writes.
- R8: Index 0x07 holds the selected device number and reads back what was written. Index 0x60 reads and writes the high byte of the selected device's base, and 0x61 the low byte. Each device keeps its own bank.
- R9: `mon_base` shows the base of device `MON_DEV` (default 4) with bits 2:0 forced to zero. It changes in the cycle after the write.
- R10: When the selected device number is `NUM_DEV` or above, 0x60 and 0x61 read 0xFF and writes to them are dropped.
- R11: While open, an unmapped index reads 0x00. Offsets other than 5 and 6 read 0xFF, and writes to them have no effect. When `rd_en` is low, `rdata` is 0x00.
- R12: While open, a read at offset 5 returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| rd_en | input | 1 | Host read strobe; `rdata` is valid in the same cycle |
| addr | input | ADDR_W | Offset within the port window |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte |
| mon_base | output | 16 | Monitor-device base, 8-byte aligned |

## Verification
Four properties are checked on every cycle. First, the key sequence state moves as the key rules require. Second, a read at the data offset while closed returns 0xFF. Third, `mon_base` holds still across writes made while closed. Fourth, a write to the monitor bank shows up masked on `mon_base` one cycle later.

Some behaviour can only be seen through the bench's scenarios. These are the separation between device banks and the handling of an out-of-range device number. They also include read-only identity bytes surviving writes and an index that survives a close and reopen. The bench compares every read against its own model of the register file.

// File: rtl/cfg_key_port.sv
module cfg_key_port #(
  parameter int          ADDR_W    = 3,
  parameter int          NUM_DEV   = 8,
  parameter int          MON_DEV   = 4,
  parameter int          WIN_BITS  = 3,
  parameter logic [15:0] CHIP_ID   = 16'h0613,
  parameter logic [15:0] VENDOR_ID = 16'h1934,
  parameter logic [15:0] BASE_RST  = 16'h0A25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [15:0]       mon_base
);
  localparam logic [ADDR_W-1:0] IDX_OFS = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] DAT_OFS = ADDR_W'(6);
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] R_SEL     = 8'h07;
  localparam logic [7:0] R_CHIP_H  = 8'h20;
  localparam logic [7:0] R_CHIP_L  = 8'h21;
  localparam logic [7:0] R_VEND_H  = 8'h23;
  localparam logic [7:0] R_VEND_L  = 8'h24;
  localparam logic [7:0] R_BASE_H  = 8'h60;
  localparam logic [7:0] R_BASE_L  = 8'h61;
  localparam logic [1:0] S_LOCK = 2'd0, S_HALF = 2'd1, S_OPEN = 2'd2;
  localparam int         SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [15:0] WIN_MASK = 16'hFFFF << WIN_BITS;

  logic [1:0] st;
  logic [7:0] idx, ldn;
  logic [7:0] bhi [NUM_DEV];
  logic [7:0] blo [NUM_DEV];

  wire is_open = (st == S_OPEN);
  wire wr_idx  = wr_en && (addr == IDX_OFS);
  wire key_hit = wr_idx && (wdata == KEY_OPEN);
  wire close   = is_open && wr_idx && (wdata == KEY_CLOSE);
  wire wr_dat  = is_open && wr_en && (addr == DAT_OFS);
  wire ldn_ok  = ({24'd0, ldn} < NUM_DEV);
  wire [SEL_W-1:0] sel = ldn[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_LOCK;
    else if (wr_en) begin
      case (st)
        S_LOCK:  st <= key_hit ? S_HALF : S_LOCK;
        S_HALF:  st <= key_hit ? S_OPEN : S_LOCK;
        default: st <= close ? S_LOCK : S_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= 8'h00;
    else if (is_open && wr_idx && !close) idx <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ldn <= 8'h00;
    else if (wr_dat && idx == R_SEL) ldn <= wdata;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
    localparam logic [15:0] RV = (d == MON_DEV) ? BASE_RST : 16'h0000;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bhi[d] <= RV[15:8];
        blo[d] <= RV[7:0];
      end else if (wr_dat && ldn == 8'(d)) begin
        if (idx == R_BASE_H) bhi[d] <= wdata;
        if (idx == R_BASE_L) blo[d] <= wdata;
      end
    end
  end

  logic [7:0] reg_val;
  always_comb begin
    case (idx)
      R_SEL:    reg_val = ldn;
      R_CHIP_H: reg_val = CHIP_ID[15:8];
      R_CHIP_L: reg_val = CHIP_ID[7:0];
      R_VEND_H: reg_val = VENDOR_ID[15:8];
      R_VEND_L: reg_val = VENDOR_ID[7:0];
      R_BASE_H: reg_val = ldn_ok ? bhi[sel] : 8'hFF;
      R_BASE_L: reg_val = ldn_ok ? blo[sel] : 8'hFF;
      default:  reg_val = 8'h00;
    endcase
  end

  always_comb begin
    if (!rd_en)                rdata = 8'h00;
    else if (addr == IDX_OFS)  rdata = is_open ? idx : 8'hFF;
    else if (addr == DAT_OFS)  rdata = is_open ? reg_val : 8'hFF;
    else                       rdata = 8'hFF;
  end

  assign mon_base = {bhi[MON_DEV], blo[MON_DEV]} & WIN_MASK;
endmodule

module cfg_key_port_chk #(
  parameter int ADDR_W   = 3,
  parameter int MON_DEV  = 4,
  parameter int WIN_BITS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [15:0]       mon_base,
  input logic [1:0]        st,
  input logic [7:0]        idx,
  input logic [7:0]        ldn
);
  localparam logic [7:0] LOW_MASK = 8'hFF << WIN_BITS;
  wire opn = (st == 2'd2);
  wire key = wr_en && addr == ADDR_W'(5) && wdata == 8'h87;

  a_r2_second_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && key) |=> (st == 2'd2));
  a_r3_break_relocks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && wr_en && !key) |=> (st == 2'd0));
  a_r4_closed_data_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!opn && rd_en && addr == ADDR_W'(6)) |-> (rdata == 8'hFF));
  a_r4_closed_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!opn && wr_en) |=> $stable(mon_base));
  a_r5_close_key: assert property (@(posedge clk) disable iff (!rst_n)
    (opn && wr_en && addr == ADDR_W'(5) && wdata == 8'hAA) |=> !opn);
  a_r9_mon_low_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (opn && wr_en && addr == ADDR_W'(6) && idx == 8'h61 && ldn == 8'(MON_DEV))
      |=> (mon_base[7:0] == ($past(wdata) & LOW_MASK)));
endmodule

bind cfg_key_port cfg_key_port_chk #(.ADDR_W(ADDR_W), .MON_DEV(MON_DEV), .WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .mon_base(mon_base),
  .st(st), .idx(idx), .ldn(ldn)
);

// File: tb/tb_cfg_key_port.sv
module tb_cfg_key_port;
  localparam int NDEV = 8;
  localparam int MDEV = 4;
  localparam logic [15:0] CHIP = 16'h0613;
  localparam logic [15:0] VEND = 16'h1934;
  localparam logic [15:0] BRST = 16'h0A25;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] mon_base;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cfg_key_port dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .mon_base(mon_base));

  bit m_half, m_open;
  logic [7:0] m_idx, m_ldn;
  logic [7:0] m_hi [NDEV];
  logic [7:0] m_lo [NDEV];

  function automatic logic [15:0] exp_base();
    return {m_hi[MDEV], m_lo[MDEV] & 8'hF8};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    if (a == 3'd5) return m_open ? m_idx : 8'hFF;
    if (a != 3'd6 || !m_open) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h23: return VEND[15:8];
      8'h24: return VEND[7:0];
      8'h60: return (m_ldn < NDEV) ? m_hi[m_ldn] : 8'hFF;
      8'h61: return (m_ldn < NDEV) ? m_lo[m_ldn] : 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (!m_open) begin
      if (a == 3'd5 && d == 8'h87) begin
        if (m_half) begin m_open = 1; m_half = 0; end else m_half = 1;
      end else m_half = 0;
    end else if (a == 3'd5) begin
      if (d == 8'hAA) m_open = 0; else m_idx = d;
    end else if (a == 3'd6) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (m_idx == 8'h60 && m_ldn < NDEV) m_hi[m_ldn] = d;
      else if (m_idx == 8'h61 && m_ldn < NDEV) m_lo[m_ldn] = d;
    end
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    chk(req, {8'h00, rdata}, {8'h00, exp});
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_half = 0; m_open = 0; m_idx = 8'h00; m_ldn = 8'h00;
    for (int d = 0; d < NDEV; d++) begin
      m_hi[d] = (d == MDEV) ? BRST[15:8] : 8'h00;
      m_lo[d] = (d == MDEV) ? BRST[7:0]  : 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 data closed", 3'd6, 8'hFF);
    rd("R1 index closed", 3'd5, 8'hFF);
    chk("R1 base reset", mon_base, 16'h0A20);

    // R4 write while closed is dropped
    wr(3'd6, 8'h55);
    chk("R4 base after closed write", mon_base, 16'h0A20);
    rd("R4 data closed read", 3'd6, 8'hFF);

    // R3 broken sequences
    wr(3'd5, 8'h87); wr(3'd5, 8'h55); wr(3'd5, 8'h87);
    rd("R3 wrong value between keys", 3'd6, 8'hFF);
    wr(3'd5, 8'hAA);
    wr(3'd5, 8'h87); wr(3'd2, 8'h87); wr(3'd5, 8'h87);
    rd("R3 other offset between keys", 3'd5, 8'hFF);
    wr(3'd5, 8'hAA);

    // R2 open
    wr(3'd5, 8'h87); wr(3'd5, 8'h87);
    rd("R2 open index read", 3'd5, 8'h00);
    rd("R11 unmapped index 00", 3'd6, 8'h00);

    // R12 and R6
    wr(3'd5, 8'h20); rd("R12 index readback", 3'd5, 8'h20);
    rd("R6 chip high", 3'd6, 8'h06);
    wr(3'd5, 8'h21); rd("R6 chip low", 3'd6, 8'h13);
    wr(3'd5, 8'h23); rd("R6 vendor high", 3'd6, 8'h19);
    wr(3'd5, 8'h24); rd("R6 vendor low", 3'd6, 8'h34);
    wr(3'd6, 8'h00); rd("R7 vendor low after write", 3'd6, 8'h34);
    wr(3'd5, 8'h20); wr(3'd6, 8'hFF); rd("R7 chip high after write", 3'd6, 8'h06);

    // R8 and R9
    wr(3'd5, 8'h07); wr(3'd6, 8'h04); rd("R8 select readback", 3'd6, 8'h04);
    wr(3'd5, 8'h60); wr(3'd6, 8'h12);
    wr(3'd5, 8'h61); wr(3'd6, 8'h3F);
    chk("R9 mon base masked", mon_base, 16'h1238);
    rd("R8 base low raw", 3'd6, 8'h3F);
    wr(3'd5, 8'h07); wr(3'd6, 8'h02);
    wr(3'd5, 8'h60); wr(3'd6, 8'hAB);
    rd("R8 device 2 bank", 3'd6, 8'hAB);
    chk("R8 monitor bank untouched", mon_base, 16'h1238);
    wr(3'd5, 8'h07); wr(3'd6, 8'h04); wr(3'd5, 8'h60);
    rd("R8 device 4 bank kept", 3'd6, 8'h12);

    // R10 out of range device
    wr(3'd5, 8'h07); wr(3'd6, 8'h09);
    wr(3'd5, 8'h60); wr(3'd6, 8'h77);
    rd("R10 out of range read", 3'd6, 8'hFF);
    wr(3'd5, 8'h07); rd("R10 select holds 09", 3'd6, 8'h09);

    // R11 other offsets and idle read
    wr(3'd1, 8'h00);
    rd("R11 offset 1 reads ff", 3'd1, 8'hFF);
    @(negedge clk); addr = 3'd5; #1;
    chk("R11 rdata idle", {8'h00, rdata}, 16'h0000);

    // R5 close
    wr(3'd5, 8'hAA);
    rd("R5 closed data", 3'd6, 8'hFF);
    rd("R5 closed index", 3'd5, 8'hFF);
    chk("R5 base kept", mon_base, 16'h1238);
    wr(3'd5, 8'h87); wr(3'd5, 8'h87);
    rd("R5 index kept over close", 3'd5, 8'h07);

    // randomized phase against model
    void'($urandom(32'd4242));
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom % 12;
      case (op)
        0, 1: wr(3'd5, 8'h87);
        2: if ($urandom % 3 == 0) wr(3'd5, 8'hAA); else wr(3'($urandom), 8'($urandom));
        3, 4, 5: begin
          logic [7:0] pick [8] = '{8'h07, 8'h20, 8'h21, 8'h23, 8'h24, 8'h60, 8'h61, 8'h3C};
          wr(3'd5, pick[$urandom % 8]);
        end
        6, 7: if (m_idx == 8'h07) wr(3'd6, 8'($urandom % 10)); else wr(3'd6, 8'($urandom));
        default: begin
          logic [2:0] a = ($urandom % 2) ? 3'd6 : (($urandom % 2) ? 3'd5 : 3'($urandom));
          rd("R8 random read vs model", a, exp_rd(a));
        end
      endcase
      if (op < 8) chk("R9 random base vs model", mon_base, exp_base());
    end

    finish_run();
  end
endmodule